// File: doc/BRIEF.md
# Unary ALU with Condition Codes

This block is the execute stage of a compact 8-bit register machine. Each clock cycle it is given one instruction word, the value of the register named by the 2-bit first operand field, and the value of the register named by the 3-bit second operand field. It returns the value to be written back, a select that says which of the two named registers receives it, and a write strobe for the register file. Two registered status bits record whether the last value produced was negative or zero.

Four single-operand operations share one adder path. They are test, increment, bitwise invert and two's-complement negate. Each one flips every operand bit with instruction bit 4 and then adds instruction bit 3. The same adder also performs register copy, small-immediate load, clear and two-register add. Instructions whose top bit is set belong to the memory and branch units. For these, the block withholds the write strobe and keeps its status bits unchanged.

Register storage, memory traffic and program counter sequencing sit outside this block. Every rising clock edge counts as one execute slot for the instruction currently on `instr`.

Top module: `alu8_exec`

## Requirements
- R1: Instruction bits are numbered 7 down to 0. Bits 7..5 are the opcode, bits 4..3 are the first operand field and bits 2..0 are the second operand field. Opcode 000 performs a single-operand operation on `opBVal`, and `destSel` is 0, meaning the second operand register is the destination.
- R2: For opcode 000, `result` = (`opBVal` XOR eight copies of bit 4) + bit 3, modulo 256. Sub-codes {bit4,bit3} = 00 pass the value, 01 add one, 10 invert it, 11 negate it. Examples: incrementing 0xFF gives 0x00, and negating 0x80 gives 0x80.
- R3: Opcode 001 sets `result` = `opAVal`, with `destSel` = 0.
- R4: Opcode 010 with bit 0 = 0 sets `result` to bits 2..0 zero-extended to 8 bits, with `destSel` = 1.
- R5: Opcode 010 with bit 0 = 1 sets `result` = 0x00, with `destSel` = 1, whatever the operand values.
- R6: Opcode 011 sets `result` = (`opAVal` + `opBVal`) modulo 256, with `destSel` = 1. The carry out is dropped.
- R7: On a rising clock edge while bit 7 = 0, `ccNeg` takes bit 7 of `result` and `ccZero` takes 1 exactly when `result` is 0x00.
- R8: On a rising clock edge while bit 7 = 1, `ccNeg` and `ccZero` keep their values, and `wrEn` is 0 throughout that cycle.
- R9: While `rstN` is low, `ccNeg` and `ccZero` are 0.
- R10: For every instruction, `destSel` equals bit 6 and `wrEn` equals the inverse of bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one execute slot |
| rstN | input | 1 | Active-low asynchronous reset of the status bits |
| instr | input | 8 | Instruction word for the current slot |
| opAVal | input | 8 | Value of the register named by bits 4..3 |
| opBVal | input | 8 | Value of the register named by bits 2..0 |
| result | output | 8 | Value to write back |
| destSel | output | 1 | 0: second operand register, 1: first operand register |
| wrEn | output | 1 | Register write strobe |
| ccNeg | output | 1 | Registered negative status bit |
| ccZero | output | 1 | Registered zero status bit |

## Verification
The bench targets wrap-around at the adder edges: incrementing 0xFF, negating 0x80 and 0x00, and an add whose carry out must be dropped. A design that keeps the carry or sign-extends would report wrong values or a wrong zero bit in these cases. It also runs memory-class instructions right after flag-setting ones; a design that loads the status bits on every edge would corrupt them there. Clear is driven with non-zero operands, and immediate loads are driven with every even field value. This exposes a decoder that confuses the two forms that share opcode 010.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  // Which value feeds the A side of the shared adder
  typedef enum logic [1:0] {
    SRC_OPB_MOD = 2'd0,  // second operand, optionally inverted
    SRC_OPA     = 2'd1,  // first operand register
    SRC_IMM     = 2'd2,  // zero-extended short immediate
    SRC_ZERO    = 2'd3   // constant zero
  } srcSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    srcSel_e srcSel;
    logic    invert;    // xor mask on the second operand
    logic    carryIn;   // +1 into the adder
    logic    addOpB;    // B side of adder takes the second operand
    logic    flagLoad;  // update the status register this edge
    logic    destOp1;   // result targets first operand register
    logic    wrEn;      // register file write strobe
  } ctrl_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [4:0] opField,  // instruction bits 7..3
  input  logic       lowBit,   // instruction bit 0
  output ctrl_t      ctrl
);

  logic [2:0] opcode;
  assign opcode = opField[4:2];

  always_comb begin
    ctrl          = '0;
    ctrl.srcSel   = SRC_ZERO;
    ctrl.flagLoad = ~opField[4];
    ctrl.wrEn     = ~opField[4];
    ctrl.destOp1  = opField[3];
    case (opcode)
      3'b000: begin  // R1 single-operand group
        ctrl.srcSel  = SRC_OPB_MOD;
        ctrl.invert  = opField[1];
        ctrl.carryIn = opField[0];
      end
      3'b001: ctrl.srcSel = SRC_OPA;
      3'b010: ctrl.srcSel = lowBit ? SRC_ZERO : SRC_IMM;
      3'b011: begin
        ctrl.srcSel = SRC_OPA;
        ctrl.addOpB = 1'b1;
      end
      default: ctrl.srcSel = SRC_ZERO;
    endcase
  end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int W     = 8,
  parameter int IMM_W = 3
) (
  input  ctrl_t            ctrl,
  input  logic [IMM_W-1:0] imm,
  input  logic [W-1:0]     opAVal,
  input  logic [W-1:0]     opBVal,
  output logic [W-1:0]     sum
);

  localparam int PAD_W = W - IMM_W;

  logic [W-1:0] addA;
  logic [W-1:0] addB;
  logic [W-1:0] cinVec;

  always_comb begin
    case (ctrl.srcSel)
      SRC_OPB_MOD: addA = opBVal ^ {W{ctrl.invert}};
      SRC_OPA:     addA = opAVal;
      SRC_IMM:     addA = {{PAD_W{1'b0}}, imm};
      default:     addA = '0;
    endcase
  end

  assign addB   = ctrl.addOpB ? opBVal : '0;
  assign cinVec = {{(W-1){1'b0}}, ctrl.carryIn};
  assign sum    = addA + addB + cinVec;  // carry out dropped

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         ccNeg,
  output logic         ccZero
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ccNeg  <= 1'b0;
      ccZero <= 1'b0;
    end else if (load) begin
      ccNeg  <= value[W-1];
      ccZero <= ~|value;
    end
  end

endmodule

// File: rtl/alu8_exec.sv
module alu8_exec
  import alu8_pkg::*;
#(
  parameter int W     = 8,
  parameter int IMM_W = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   instr,
  input  logic [W-1:0] opAVal,
  input  logic [W-1:0] opBVal,
  output logic [W-1:0] result,
  output logic         destSel,
  output logic         wrEn,
  output logic         ccNeg,
  output logic         ccZero
);

  ctrl_t ctrl;

  alu8_ctrl u_ctrl (
    .opField (instr[7:3]),
    .lowBit  (instr[0]),
    .ctrl    (ctrl)
  );

  alu8_datapath #(.W(W), .IMM_W(IMM_W)) u_dp (
    .ctrl   (ctrl),
    .imm    (instr[IMM_W-1:0]),
    .opAVal (opAVal),
    .opBVal (opBVal),
    .sum    (result)
  );

  alu8_flags #(.W(W)) u_flags (
    .clk    (clk),
    .rstN   (rstN),
    .load   (ctrl.flagLoad),
    .value  (result),
    .ccNeg  (ccNeg),
    .ccZero (ccZero)
  );

  assign destSel = ctrl.destOp1;
  assign wrEn    = ctrl.wrEn;

endmodule

// File: rtl/alu8_exec_chk.sv
module alu8_exec_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic [7:0]   instr,
  input logic [W-1:0] opAVal,
  input logic [W-1:0] opBVal,
  input logic [W-1:0] result,
  input logic         wrEn,
  input logic         ccNeg,
  input logic         ccZero
);

  a_r2_unary_math: assert property (@(posedge clk) disable iff (!rstN)
    (instr[7:5] == 3'b000) |->
      (result == ((opBVal ^ {W{instr[4]}}) + {{(W-1){1'b0}}, instr[3]})));

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    (instr[7:5] == 3'b010 && instr[0]) |-> (result == '0));

  a_r6_add_sum: assert property (@(posedge clk) disable iff (!rstN)
    (instr[7:5] == 3'b011) |-> (result == W'(opAVal + opBVal)));

  a_r7_flag_update: assert property (@(posedge clk) disable iff (!rstN)
    !instr[7] |=> (ccNeg == $past(result[W-1]) && ccZero == ($past(result) == '0)));

  a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    instr[7] |=> ($stable(ccNeg) && $stable(ccZero)));

  a_r8_no_write: assert property (@(posedge clk) disable iff (!rstN)
    instr[7] |-> !wrEn);

  always_comb begin
    if (!rstN) a_r9_reset_flags: assert (!ccNeg && !ccZero);
  end

endmodule

bind alu8_exec alu8_exec_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .instr  (instr),
  .opAVal (opAVal),
  .opBVal (opBVal),
  .result (result),
  .wrEn   (wrEn),
  .ccNeg  (ccNeg),
  .ccZero (ccZero)
);

// File: tb/alu8_exec_bench.sv
module alu8_exec_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] instr;
  logic [7:0] opAVal;
  logic [7:0] opBVal;
  logic [7:0] result;
  logic       destSel;
  logic       wrEn;
  logic       ccNeg;
  logic       ccZero;

  int checks   = 0;
  int failures = 0;
  logic expN = 1'b0;
  logic expZ = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  alu8_exec u_alu8_exec (
    .clk(clk), .rstN(rstN), .instr(instr), .opAVal(opAVal), .opBVal(opBVal),
    .result(result), .destSel(destSel), .wrEn(wrEn), .ccNeg(ccNeg), .ccZero(ccZero)
  );

  function automatic logic [7:0] expRes(input logic [7:0] ins, input logic [7:0] a,
                                        input logic [7:0] b);
    case (ins[7:5])
      3'b000:  return (b ^ {8{ins[4]}}) + {7'b0, ins[3]};
      3'b001:  return a;
      3'b010:  return ins[0] ? 8'h00 : {5'b0, ins[2:0]};
      3'b011:  return a + b;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string reqTag(input logic [7:0] ins);
    case (ins[7:5])
      3'b000:  return "R2";
      3'b001:  return "R3";
      3'b010:  return ins[0] ? "R5" : "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] ins, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    @(negedge clk);
    instr = ins; opAVal = a; opBVal = b;
    #5;
    r = expRes(ins, a, b);
    if (!ins[7]) chk(reqTag(ins), result, r);
    chk((ins[7:5] == 3'b000) ? "R1" : "R10", {destSel, wrEn}, {ins[6], ~ins[7]});
    if (!ins[7]) begin
      expN = r[7];
      expZ = (r == 8'h00);
    end
    @(posedge clk);
    #5;
    chk(ins[7] ? "R8" : "R7", {ccNeg, ccZero}, {expN, expZ});
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rstN = 1'b0; instr = 8'h00; opAVal = 8'h00; opBVal = 8'h00;
    repeat (3) @(posedge clk);
    #5;
    chk("R9", {ccNeg, ccZero}, 2'b00);  // a zero test would set Z if not in reset
    @(negedge clk);
    rstN = 1'b1;

    // Directed corners
    run(8'h08, 8'h00, 8'hFF);  // increment wraps to zero (R2)
    run(8'h18, 8'h00, 8'h80);  // negate 0x80 -> 0x80, N set
    run(8'h18, 8'h00, 8'h00);  // negate zero -> zero
    run(8'h10, 8'h00, 8'h5A);  // invert
    run(8'h00, 8'h00, 8'h80);  // test sets N
    run(8'h80, 8'h00, 8'h00);  // memory class: flags hold (R8)
    run(8'hE5, 8'h00, 8'h00);  // call-like: hold
    run(8'h2A, 8'hC3, 8'h11);  // copy (R3)
    run(8'h49, 8'hFF, 8'hFF);  // clear with nonzero operands (R5)
    run(8'h7B, 8'hF0, 8'h20);  // add drops carry (R6)
    run(8'h72, 8'h80, 8'h80);  // add to zero sets Z
    run(8'hA0, 8'h00, 8'h00);  // hold Z
    for (int k = 0; k < 8; k += 2) run(8'h40 | 8'(k), 8'hAA, 8'h55);  // immediates (R4)

    for (int n = 0; n < 3000; n++) begin
      run(8'($urandom), 8'($urandom), 8'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule